// File: doc/BRIEF.md
# DDR3 Multi-Purpose Register Read Responder

This block stands in for the memory-side logic that answers read commands while the DRAM's multi-purpose register (MPR) mode is on. A mode-register write to MR3 turns the mode on and picks a register location. While the mode is on, every read command returns a fixed burst of single-bit beats, spread over an x16 data bus. The data is not taken from the memory array. It comes from a predefined calibration pattern, or from all zeros when a reserved location is selected.

Three things set the beat order and the burst length. Address bit A2 of the read picks the nibble. The MR0 burst-length setting chooses a fixed 8-beat burst, a fixed 4-beat chop, or on-the-fly selection through A12. The first beat leaves the block a fixed read latency after the command. A single-cycle flag reports each of the following: an illegal MPR read address, a read issued while the DLL is unlocked, and a normal read issued while the mode is off. The normal array read path is not modelled, so such a read only raises its flag.

Commands are assumed to be spaced at least one burst apart. If a new burst reaches the output stage while an earlier one is still running, the new burst takes over.

Top module: `mpr_read_responder`

## Requirements
- R1: Reset leaves MPR mode off. A cycle with `mr3_wr`=1 sets the mode to `mr3_bits[2]` and the location to `mr3_bits[1:0]`. A later MR3 write with bit 2 at 0 turns the mode off again.
- R2: A `rd_cmd` while MPR mode is off pulses `rd_normal` for exactly the one cycle after the command edge, and produces no data beats.
- R3: Location 00 returns the bits of the `PATTERN` parameter. Bit 0 of the location is output first in ascending order. The default pattern is 0,1,0,1,0,1,0,1 in burst order (bit i = i mod 2, value 8'hAA).
- R4: The burst length follows `mr0_bl`: 00 gives 8 beats; 01 uses `rd_addr[12]` (0 gives 4 beats, 1 gives 8 beats); 10 gives 4 beats; 11 gives 8 beats.
- R5: An 8-beat burst outputs location bits 0..7 in order. A 4-beat burst with `rd_addr[2]`=0 outputs bits 0..3, and with `rd_addr[2]`=1 outputs bits 4..7.
- R6: A read with `rd_addr[1:0]` other than 00, or with `rd_addr[2]`=1 in an 8-beat burst, pulses `err_proto` in the cycle after the command. The burst is still returned, in the order for that burst length with `rd_addr[1:0]` taken as 00 (for 8 beats, bits 0..7).
- R7: `rd_bank`, `rd_addr[11:3]` and `rd_addr[15:13]` have no effect on the beats or the flags of an MPR read.
- R8: Locations 01, 10 and 11 return all-zero beats, with the same valid, last and timing behaviour as location 00.
- R9: A command sampled at clock edge E gives its first beat with `dq_valid`=1 in the cycle after edge E+`RD_LAT`. The remaining beats follow on consecutive cycles, and `dq_valid` drops after the last one.
- R10: `dq_last` is 1 on the 4th beat of a chop and on the 8th beat of a full burst, and 0 on every other cycle.
- R11: Bits 0 and 8 of `dq_data` carry the beat bit. The other 14 bits repeat it when `lane_fill`=1 and are 0 when `lane_fill`=0. `dq_data` is 0 whenever `dq_valid` is 0.
- R12: A read while MPR mode is on and `dll_locked`=0 pulses `err_dll` in the cycle after the command. It drives no beats and raises no `err_proto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr3_wr | input | 1 | Mode-register write to MR3 this cycle |
| mr3_bits | input | 3 | MR3 address bits: [2] mode enable, [1:0] location |
| mr0_bl | input | 2 | Burst-length setting from MR0 |
| dll_locked | input | 1 | DLL lock indication |
| rd_cmd | input | 1 | Read command this cycle |
| rd_addr | input | 16 | Read command address A[15:0] |
| rd_bank | input | 3 | Read command bank address |
| lane_fill | input | 1 | 1: upper bits of each byte lane copy the beat bit; 0: they are driven to 0 |
| dq_valid | output | 1 | A data beat is present this cycle |
| dq_data | output | 16 | Beat data on both byte lanes |
| dq_last | output | 1 | Final beat of the burst |
| err_proto | output | 1 | Illegal MPR read address (one-cycle pulse) |
| err_dll | output | 1 | MPR read while the DLL is unlocked (one-cycle pulse) |
| rd_normal | output | 1 | Read while MPR mode is off (one-cycle pulse) |

## Verification
A stale mode or location register shows within one read: the flag class changes, or the beats become zero or non-zero, in the cycle after the command or `RD_LAT` cycles later. A wrong burst descriptor or beat counter shows on the first burst: a wrong beat value, `dq_last` on the wrong cycle, or `dq_valid` held one cycle too long or too short. Nibble selection cannot be seen with the default alternating pattern, so a second instance with an asymmetric pattern is driven with the same stimulus. With that instance, a wrong A2 or chop decode shows on the first chop beat.

// File: rtl/mpr_resp_pkg.sv
// Package: shared types for the MPR read responder.
// Assumes: MR0 burst-length codes follow the DDR3 field encoding.
package mpr_resp_pkg;

    // MR0 burst-length field codes
    typedef enum logic [1:0] {
        BLM_FIXED8     = 2'b00,
        BLM_ON_THE_FLY = 2'b01,
        BLM_FIXED4     = 2'b10,
        BLM_RSVD       = 2'b11
    } blm_e;

    // What a burst needs once it has been accepted
    typedef struct packed {
        logic chop;   // 4-beat burst
        logic upper;  // second nibble of the location
        logic zero;   // reserved location: all-zero beats
    } burst_desc_t;

    localparam int BEATS_FULL = 8;
    localparam int BEATS_CHOP = 4;

endpackage

// File: rtl/mpr_mode_reg.sv
// Module: holds the MR3 state (MPR enable and location select).
// Assumes: an MR3 write is one cycle wide; a read in the same cycle sees the old state.
module mpr_mode_reg #(
    parameter int LOC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr3_wr,
    input  logic             en_bit,
    input  logic [LOC_W-1:0] loc_bits,
    output logic             mpr_en,
    output logic [LOC_W-1:0] mpr_loc
);

    // Latch enable and location on an MR3 write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mpr_en  <= 1'b0;
            mpr_loc <= '0;
        end else if (mr3_wr) begin
            mpr_en  <= en_bit;
            mpr_loc <= loc_bits;
        end
    end

endmodule

// File: rtl/mpr_cmd_decode.sv
// Module: decodes a read command into a burst descriptor and the status flags.
// Assumes: only A[2:0] and A12 matter; every other address and bank bit is ignored.
module mpr_cmd_decode
    import mpr_resp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LOC_W  = 2,
    parameter int BC_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        mr0_bl,
    input  logic              dll_locked,
    input  logic              mpr_en,
    input  logic [LOC_W-1:0]  mpr_loc,
    output logic              launch,
    output burst_desc_t       desc,
    output logic              err_proto,
    output logic              err_dll,
    output logic              rd_normal
);

    logic bad_addr;
    blm_e blm;

    assign blm = blm_e'(mr0_bl);

    // Burst length from the MR0 setting and, on the fly, from A12
    always_comb begin
        case (blm)
            BLM_FIXED8:     desc.chop = 1'b0;
            BLM_ON_THE_FLY: desc.chop = ~rd_addr[BC_BIT];
            BLM_FIXED4:     desc.chop = 1'b1;
            default:        desc.chop = 1'b0;
        endcase
    end

    // Nibble select is honoured only for chops; reserved locations read zero
    always_comb begin
        desc.upper = desc.chop & rd_addr[2];
        desc.zero  = (mpr_loc != '0);
        bad_addr   = (rd_addr[1:0] != 2'b00) | (~desc.chop & rd_addr[2]);
    end

    assign launch = rd_cmd & mpr_en & dll_locked;

    // Register the one-cycle status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_proto <= 1'b0;
            err_dll   <= 1'b0;
            rd_normal <= 1'b0;
        end else begin
            err_proto <= launch & bad_addr;
            err_dll   <= rd_cmd & mpr_en & ~dll_locked;
            rd_normal <= rd_cmd & ~mpr_en;
        end
    end

endmodule

// File: rtl/mpr_latency_pipe.sv
// Module: delays an accepted burst by DEPTH cycles to model the read latency.
// Assumes: DEPTH >= 1.
module mpr_latency_pipe
    import mpr_resp_pkg::*;
#(
    parameter int DEPTH = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  burst_desc_t in_desc,
    output logic        out_vld,
    output burst_desc_t out_desc
);

    logic        stg_vld  [DEPTH];
    burst_desc_t stg_desc [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            // First stage takes the decoded command
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_vld[s]  <= 1'b0;
                    stg_desc[s] <= '0;
                end else begin
                    stg_vld[s]  <= in_vld;
                    stg_desc[s] <= in_desc;
                end
            end
        end else begin : g_body
            // Later stages shift the entry along by one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_vld[s]  <= 1'b0;
                    stg_desc[s] <= '0;
                end else begin
                    stg_vld[s]  <= stg_vld[s-1];
                    stg_desc[s] <= stg_desc[s-1];
                end
            end
        end
    end

    assign out_vld  = stg_vld[DEPTH-1];
    assign out_desc = stg_desc[DEPTH-1];

endmodule

// File: rtl/mpr_beat_seq.sv
// Module: plays out one burst of location bits and maps each bit onto the byte lanes.
// Assumes: a start while a burst is running restarts with the new burst.
module mpr_beat_seq
    import mpr_resp_pkg::*;
#(
    parameter int                  LANE_W  = 8,
    parameter int                  LANES   = 2,
    parameter logic [BEATS_FULL-1:0] PATTERN = 8'hAA
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  burst_desc_t             desc,
    input  logic                    lane_fill,
    output logic                    dq_valid,
    output logic [LANES*LANE_W-1:0] dq_data,
    output logic                    dq_last
);

    localparam int IDX_W  = $clog2(BEATS_FULL);
    localparam int NIB_W  = $clog2(BEATS_CHOP);
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(BEATS_FULL - 1);
    localparam logic [IDX_W-1:0] LAST_CHOP = IDX_W'(BEATS_CHOP - 1);

    logic              active;
    logic [IDX_W-1:0]  cnt;
    burst_desc_t       cur;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  bit_idx;
    logic              beat_bit;
    logic              at_last;

    assign last_idx = cur.chop ? LAST_CHOP : LAST_FULL;
    assign at_last  = active && (cnt == last_idx);

    // Beat counter and the burst held for its duration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            cur    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            cur    <= desc;
        end else if (at_last) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            cnt    <= cnt + 1'b1;
        end
    end

    // Pick the location bit: a chop keeps the nibble fixed by A2
    always_comb begin
        if (cur.chop) bit_idx = {cur.upper, cnt[NIB_W-1:0]};
        else          bit_idx = cnt;
        beat_bit = active & ~cur.zero & PATTERN[bit_idx];
    end

    assign dq_valid = active;
    assign dq_last  = at_last;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_data[g*LANE_W]                 = beat_bit;
        assign dq_data[g*LANE_W+1 +: LANE_W-1]  = {(LANE_W-1){beat_bit & lane_fill}};
    end

endmodule

// File: rtl/mpr_read_responder.sv
// Module: top of the MPR read responder; MR3 state, read decode, latency, beat output.
// Assumes: reads spaced at least one burst apart; RD_LAT >= 1.
module mpr_read_responder
    import mpr_resp_pkg::*;
#(
    parameter int                    RD_LAT  = 5,
    parameter int                    ADDR_W  = 16,
    parameter int                    BANK_W  = 3,
    parameter int                    LANE_W  = 8,
    parameter int                    LANES   = 2,
    parameter logic [BEATS_FULL-1:0] PATTERN = 8'hAA
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mr3_wr,
    input  logic [2:0]              mr3_bits,
    input  logic [1:0]              mr0_bl,
    input  logic                    dll_locked,
    input  logic                    rd_cmd,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [BANK_W-1:0]       rd_bank,
    input  logic                    lane_fill,
    output logic                    dq_valid,
    output logic [LANES*LANE_W-1:0] dq_data,
    output logic                    dq_last,
    output logic                    err_proto,
    output logic                    err_dll,
    output logic                    rd_normal
);

    localparam int LOC_W = 2;

    logic             mpr_en;
    logic [LOC_W-1:0] mpr_loc;
    logic             launch;
    burst_desc_t      dec_desc;
    logic             pipe_vld;
    burst_desc_t      pipe_desc;

    mpr_mode_reg #(.LOC_W(LOC_W)) mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mr3_wr   (mr3_wr),
        .en_bit   (mr3_bits[2]),
        .loc_bits (mr3_bits[LOC_W-1:0]),
        .mpr_en   (mpr_en),
        .mpr_loc  (mpr_loc)
    );

    mpr_cmd_decode #(.ADDR_W(ADDR_W), .LOC_W(LOC_W)) dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .rd_addr    (rd_addr),
        .mr0_bl     (mr0_bl),
        .dll_locked (dll_locked),
        .mpr_en     (mpr_en),
        .mpr_loc    (mpr_loc),
        .launch     (launch),
        .desc       (dec_desc),
        .err_proto  (err_proto),
        .err_dll    (err_dll),
        .rd_normal  (rd_normal)
    );

    mpr_latency_pipe #(.DEPTH(RD_LAT)) pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (launch),
        .in_desc  (dec_desc),
        .out_vld  (pipe_vld),
        .out_desc (pipe_desc)
    );

    mpr_beat_seq #(.LANE_W(LANE_W), .LANES(LANES), .PATTERN(PATTERN)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pipe_vld),
        .desc      (pipe_desc),
        .lane_fill (lane_fill),
        .dq_valid  (dq_valid),
        .dq_data   (dq_data),
        .dq_last   (dq_last)
    );

endmodule

// File: rtl/mpr_resp_checker.sv
// Module: protocol properties of the MPR read responder, attached by bind.
// Assumes: two byte lanes, as on an x16 bus.
module mpr_resp_checker #(
    parameter int LANE_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_cmd,
    input logic                  dll_locked,
    input logic                  lane_fill,
    input logic                  mpr_en,
    input logic                  dq_valid,
    input logic [2*LANE_W-1:0]   dq_data,
    input logic                  dq_last,
    input logic                  err_proto,
    input logic                  err_dll,
    input logic                  rd_normal
);

    // R10: the last flag only marks a real beat
    p_last_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_last |-> dq_valid);

    // R10: last flag is a single-cycle marker
    p_last_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_last |=> !dq_last);

    // R11: bus is quiet between beats
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (dq_data == '0));

    // R11: both byte lanes carry the same beat bit
    p_lane_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> (dq_data[0] == dq_data[LANE_W]));

    // R11: with fill off, only bit 0 of each lane may be set
    p_lane_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !lane_fill) |->
            (dq_data[LANE_W-1:1] == '0) && (dq_data[2*LANE_W-1:LANE_W+1] == '0));

    // R12: unlocked DLL gives the DLL flag and never the address flag
    p_dll_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && mpr_en && !dll_locked) |=> (err_dll && !err_proto));

    // R2: read with the mode off is flagged as a normal read
    p_normal_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !mpr_en) |=> rd_normal);

    // R12: at most one status flag at a time
    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_proto, err_dll, rd_normal}));

endmodule

bind mpr_read_responder mpr_resp_checker #(.LANE_W(LANE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_cmd     (rd_cmd),
    .dll_locked (dll_locked),
    .lane_fill  (lane_fill),
    .mpr_en     (mpr_en),
    .dq_valid   (dq_valid),
    .dq_data    (dq_data),
    .dq_last    (dq_last),
    .err_proto  (err_proto),
    .err_dll    (err_dll),
    .rd_normal  (rd_normal)
);

// File: tb/mpr_read_responder_tb_top.sv
// Bench: sweeps location, burst setting, A12, A2, ignored bits and lane fill.
// A second instance with an asymmetric pattern makes the nibble order visible.
module mpr_read_responder_tb_top;

    localparam int         RL      = 5;
    localparam logic [7:0] PAT_DEF = 8'hAA;
    localparam logic [7:0] PAT_ALT = 8'b1100_1001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mr3_wr = 1'b0;
    logic [2:0]  mr3_bits = '0;
    logic [1:0]  mr0_bl = '0;
    logic        dll_locked = 1'b1;
    logic        rd_cmd = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [2:0]  rd_bank = '0;
    logic        lane_fill = 1'b0;

    logic        a_valid, a_last, a_eproto, a_edll, a_norm;
    logic [15:0] a_data;
    logic        b_valid, b_last, b_eproto, b_edll, b_norm;
    logic [15:0] b_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state
    bit       m_en  = 1'b0;
    bit [1:0] m_loc = 2'b00;

    always #2 clk = ~clk;

    mpr_read_responder #(.RD_LAT(RL), .PATTERN(PAT_DEF)) dut_i (
        .clk(clk), .rst_n(rst_n), .mr3_wr(mr3_wr), .mr3_bits(mr3_bits),
        .mr0_bl(mr0_bl), .dll_locked(dll_locked), .rd_cmd(rd_cmd),
        .rd_addr(rd_addr), .rd_bank(rd_bank), .lane_fill(lane_fill),
        .dq_valid(a_valid), .dq_data(a_data), .dq_last(a_last),
        .err_proto(a_eproto), .err_dll(a_edll), .rd_normal(a_norm)
    );

    mpr_read_responder #(.RD_LAT(RL), .PATTERN(PAT_ALT)) alt_i (
        .clk(clk), .rst_n(rst_n), .mr3_wr(mr3_wr), .mr3_bits(mr3_bits),
        .mr0_bl(mr0_bl), .dll_locked(dll_locked), .rd_cmd(rd_cmd),
        .rd_addr(rd_addr), .rd_bank(rd_bank), .lane_fill(lane_fill),
        .dq_valid(b_valid), .dq_data(b_data), .dq_last(b_last),
        .err_proto(b_eproto), .err_dll(b_edll), .rd_normal(b_norm)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input logic b, input logic fill);
        logic [7:0] lane;
        lane = fill ? {8{b}} : {7'b0, b};
        return {lane, lane};
    endfunction

    task automatic mr3_write(input bit en, input bit [1:0] loc);
        @(negedge clk);
        mr3_wr = 1'b1; mr3_bits = {en, loc};
        @(negedge clk);
        mr3_wr = 1'b0; mr3_bits = 3'b000;
        m_en = en; m_loc = loc;
    endtask

    // Issue one read; predict flags, beat count, order and values.
    task automatic do_read(input logic [15:0] addr, input logic [2:0] bank);
        int  n;
        bit  chop, upper, proto, beats;
        bit  e_norm, e_dll;
        @(negedge clk);
        rd_cmd = 1'b1; rd_addr = addr; rd_bank = bank;
        @(posedge clk);   // command edge E
        @(negedge clk);
        rd_cmd = 1'b0; rd_addr = '0; rd_bank = '0;

        n     = (mr0_bl == 2'b10) ? 4 : (mr0_bl == 2'b01) ? (addr[12] ? 8 : 4) : 8;
        chop  = (n == 4);
        upper = chop && addr[2];
        e_norm = !m_en;
        e_dll  = m_en && !dll_locked;
        beats  = m_en && dll_locked;
        proto  = beats && ((addr[1:0] != 2'b00) || (!chop && addr[2]));

        // R2 R6 R12: flags one cycle after the command edge
        chk(a_norm == e_norm && b_norm == e_norm, "R2 rd_normal", 32'(a_norm), 32'(e_norm));
        chk(a_eproto == proto && b_eproto == proto, "R6 err_proto", 32'(a_eproto), 32'(proto));
        chk(a_edll == e_dll && b_edll == e_dll, "R12 err_dll", 32'(a_edll), 32'(e_dll));

        for (int m = 1; m <= RL + 9; m++) begin
            int  j;
            bit  e_v, e_l;
            logic [15:0] ea, eb;
            int  idx;
            @(posedge clk);
            @(negedge clk);
            j   = m - RL;
            e_v = beats && (j >= 0) && (j < n);
            e_l = e_v && (j == n - 1);
            idx = upper ? 4 + j : j;
            ea  = e_v ? word_of((m_loc == 2'b00) ? PAT_DEF[idx[2:0]] : 1'b0, lane_fill) : 16'h0;
            eb  = e_v ? word_of((m_loc == 2'b00) ? PAT_ALT[idx[2:0]] : 1'b0, lane_fill) : 16'h0;
            // R4 R9 R12: valid window (length and latency)
            chk(a_valid == e_v && b_valid == e_v, "R9 dq_valid", 32'(a_valid), 32'(e_v));
            // R10: last beat marker
            chk(a_last == e_l && b_last == e_l, "R10 dq_last", 32'(a_last), 32'(e_l));
            // R3 R5 R8 R11: data on the default pattern
            chk(a_data == ea, "R3 dq_data", 32'(a_data), 32'(ea));
            // R5 R6 R7: data on the asymmetric pattern shows the nibble order
            chk(b_data == eb, "R5 dq_data alt", 32'(b_data), 32'(eb));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, nothing on the bus
        chk(!a_valid && !a_last && !a_eproto && !a_edll && !a_norm && a_data == 0,
            "R1 reset outputs", {27'd0, a_valid, a_last, a_eproto, a_edll, a_norm}, 32'd0);
        // R1 R2: mode off after reset, a read is a normal read
        do_read(16'h0000, 3'b000);

        // Main sweep over location, burst setting, A12, A2 and address variants
        for (int loc = 0; loc < 4; loc++) begin
            mr3_write(1'b1, 2'(loc));
            for (int bl = 0; bl < 4; bl++) begin
                mr0_bl = 2'(bl);
                for (int a12 = 0; a12 < 2; a12++) begin
                    for (int a2 = 0; a2 < 2; a2++) begin
                        for (int v = 0; v < 3; v++) begin
                            logic [15:0] ad;
                            logic [2:0]  bk;
                            ad = '0; bk = '0;
                            ad[12] = 1'(a12);
                            ad[2]  = 1'(a2);
                            // R7: ignored bank and address bits set
                            if (v == 1) begin ad = ad | 16'hEFF8; ad[12] = 1'(a12); bk = 3'b101; end
                            // R6: illegal low address bits
                            if (v == 2) ad[1:0] = 2'(1 + (loc % 3));
                            lane_fill = 1'(a2 ^ a12 ^ v[0] ^ loc[0]);
                            do_read(ad, bk);
                        end
                    end
                end
            end
        end

        // R12: DLL unlocked, including an illegal address
        mr3_write(1'b1, 2'b00);
        mr0_bl = 2'b00;
        dll_locked = 1'b0;
        do_read(16'h0006, 3'b000);
        do_read(16'h0000, 3'b010);
        dll_locked = 1'b1;

        // R1: disabling the mode turns reads back into normal reads
        mr3_write(1'b0, 2'b00);
        do_read(16'h0000, 3'b000);
        // R1: re-enable and read again
        mr3_write(1'b1, 2'b00);
        lane_fill = 1'b1;
        do_read(16'h0000, 3'b000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule